// File: doc/BRIEF.md
# Multiplexed-Bus Boot Memory Front End

This block connects a processor of the 8088 class to a tiny on-chip boot memory. It replaces the external transparent latch and bus transceiver that such a processor normally needs. The low byte of the 20-bit address shares its pins with the data bus. The block captures the full address when the address strobe falls. It decides whether that address lies in the sixteen-byte window at the top of memory, and during read cycles it returns opcode bytes on the data lines. Inside the window the bytes come from a small boot image. Everywhere else the block returns the one-byte no-operation opcode, so a processor that strays from the window keeps stepping forward harmlessly.

The boot image loads 0x04 into the accumulator, sends it to I/O port zero and jumps back to itself. The block therefore also captures an I/O write to port zero into an 8-bit output register, which drives indicator lights. All bus strobes are asynchronous to the system clock. Each one passes through a two-stage synchroniser, and an edge detector then turns it into a one-clock event. The bus pins are sampled through matching two-stage registers, so the address or data that is captured lines up with the strobe edge. The data lines are shown as a value plus an output enable; the pad ring turns these into a tri-state pin.

Top module: `mbus_boot_rom`

## Requirements
- R1: The latched address `addr_o` is the value on {`addr_hi_i`, `ad_i`} at the falling edge of `ale_i`. It appears three clock edges after the falling edge, counting the first edge that sees `ale_i` low, and it holds until the next falling edge of `ale_i`, whatever `ad_i` does in between.
- R2: `cs_o` is 1 exactly when the latched address lies in 0xFFFF0 to 0xFFFFF inclusive. It is updated on the same edge as `addr_o`.
- R3: During a read with `cs_o` at 1, `ad_o` returns the boot byte selected by `addr_o[3:0]`. Indices 0 to 5 hold B0 04 E6 00 EB FA in that order. Indices 6 to 15 hold 0x90.
- R4: During a read with `cs_o` at 0, `ad_o` is 0x90.
- R5: `ad_oe` is 1 only while the synchronised `rd_n_i` is low. It rises two clock edges after `rd_n_i` falls and drops two clock edges after `rd_n_i` rises.
- R6: A rising edge of `wr_n_i` while `io_m_i` is 1 (1 means I/O, 0 means memory) and the latched address is 0x00000 loads the value on `ad_i` into `led_o`. The new value is visible three clock edges after the rising edge.
- R7: Writes with `io_m_i` at 0, or to a nonzero latched address, leave `led_o` unchanged.
- R8: A synchronous active-high `rst` clears `addr_o`, `cs_o` and `led_o` and forces `ad_oe` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_hi_i | input | 12 | Address bits 19..8 from the processor |
| ad_i | input | 8 | Shared address-low / data lines, input side |
| ale_i | input | 1 | Address strobe, active high |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| io_m_i | input | 1 | Cycle type: 1 for I/O, 0 for memory |
| ad_o | output | 8 | Byte driven onto the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| addr_o | output | 20 | Latched 20-bit address |
| cs_o | output | 1 | Boot window select |
| led_o | output | 8 | Port-zero output register |

## Verification
If the address latch holds a wrong value, the fault shows at `addr_o` on the read that follows the strobe. It also shows as a wrong byte on `ad_o`: an image byte appears where 0x90 belongs, or the other way round. A wrong window decode shows the same way, and also as a `cs_o` that disagrees with `addr_o[19:4]`. A wrong edge detector or synchroniser depth shows within one or two cycles, as an `ad_oe` that does not keep its two-edge latency or a `led_o` that changes without a port-zero I/O write. None of these faults waits longer than the bus cycle it corrupts.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

  localparam int ADDR_W_DEF = 20;
  localparam int BYTE_W     = 8;
  localparam logic [BYTE_W-1:0] NOP_OP = 8'h90;

  // True when a sits inside [base, base+depth-1]
  function automatic logic in_window(input logic [ADDR_W_DEF-1:0] a,
                                     input logic [ADDR_W_DEF-1:0] base,
                                     input int unsigned depth);
    logic [ADDR_W_DEF:0] top;
    top = {1'b0, base} + (ADDR_W_DEF+1)'(depth) - 1'b1;
    return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} <= top);
  endfunction

  // True for an I/O write aimed at port zero
  function automatic logic port0_hit(input logic is_io,
                                     input logic [ADDR_W_DEF-1:0] a);
    return is_io && (a == '0);
  endfunction

endpackage

// File: rtl/mbr_sync2.sv
module mbr_sync2 #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/mbr_edge.sv
module mbr_edge #(
  parameter bit   FALLING = 1'b0,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic evt
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  generate
    if (FALLING) begin : g_fall
      assign evt = prev & ~lvl;
    end else begin : g_rise
      assign evt = ~prev & lvl;
    end
  endgenerate
endmodule

// File: rtl/mbr_addr_latch.sv
module mbr_addr_latch
  import mbr_pkg::*;
#(
  parameter int                  ADDR_W    = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0]   WIN_BASE  = 20'hFFFF0,
  parameter int                  WIN_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_evt,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cs_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cs_q   <= 1'b0;
    end else if (latch_evt) begin
      addr_q <= bus_addr;
      cs_q   <= in_window(bus_addr, WIN_BASE, WIN_DEPTH);
    end
  end
endmodule

// File: rtl/mbr_boot_rom.sv
module mbr_boot_rom
  import mbr_pkg::*;
#(
  parameter int                    DEPTH   = 16,
  parameter int                    IMG_LEN = 6,
  parameter logic [IMG_LEN*8-1:0]  IMG     = 48'hB004_E600_EBFA,
  localparam int                   IDX_W   = $clog2(DEPTH)
) (
  input  logic             cs,
  input  logic             rd_act,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       data,
  output logic             oe
);
  logic [7:0] mem [DEPTH];

  // Image bytes first (first byte in the top bits), then no-op fill
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      if (i < IMG_LEN) begin : g_img
        assign mem[i] = IMG[(IMG_LEN-1-i)*8 +: 8];
      end else begin : g_fill
        assign mem[i] = NOP_OP;
      end
    end
  endgenerate

  always_comb begin
    oe   = rd_act;
    data = 8'h00;
    if (rd_act) data = cs ? mem[idx] : NOP_OP;
  end
endmodule

// File: rtl/mbr_port_out.sv
module mbr_port_out
  import mbr_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_evt,
  input  logic              is_io,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        q
);
  always_ff @(posedge clk) begin
    if (rst)                                  q <= '0;
    else if (wr_evt && port0_hit(is_io, addr)) q <= wdata;
  end
endmodule

// File: rtl/mbus_boot_rom.sv
module mbus_boot_rom
  import mbr_pkg::*;
#(
  parameter int                  ADDR_W    = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0]   WIN_BASE  = 20'hFFFF0,
  parameter int                  ROM_DEPTH = 16,
  localparam int                 HI_W      = ADDR_W - 8,
  localparam int                 IDX_W     = $clog2(ROM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic [7:0]        ad_i,
  input  logic              ale_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              io_m_i,
  output logic [7:0]        ad_o,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cs_o,
  output logic [7:0]        led_o
);
  // Synchronised strobes: {ale, rd_n, wr_n, io}
  logic [3:0]        strb_s;
  logic [ADDR_W-1:0] bus_s;
  logic              ale_s, rd_n_s, wr_n_s, io_s;

  // Named internal events
  logic ale_fall_evt;
  logic wr_rise_evt;
  logic rd_active;

  mbr_sync2 #(.W(4), .RST_VAL(4'b0110)) u_strb_sync (
    .clk(clk), .rst(rst),
    .d({ale_i, rd_n_i, wr_n_i, io_m_i}),
    .q(strb_s)
  );

  mbr_sync2 #(.W(ADDR_W), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst(rst),
    .d({addr_hi_i, ad_i}),
    .q(bus_s)
  );

  assign {ale_s, rd_n_s, wr_n_s, io_s} = strb_s;
  assign rd_active = ~rd_n_s;

  mbr_edge #(.FALLING(1'b1), .RST_VAL(1'b0)) u_ale_edge (
    .clk(clk), .rst(rst), .lvl(ale_s), .evt(ale_fall_evt)
  );

  mbr_edge #(.FALLING(1'b0), .RST_VAL(1'b1)) u_wr_edge (
    .clk(clk), .rst(rst), .lvl(wr_n_s), .evt(wr_rise_evt)
  );

  mbr_addr_latch #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_DEPTH(ROM_DEPTH)) u_latch (
    .clk(clk), .rst(rst),
    .latch_evt(ale_fall_evt),
    .bus_addr(bus_s),
    .addr_q(addr_o),
    .cs_q(cs_o)
  );

  mbr_boot_rom #(.DEPTH(ROM_DEPTH)) u_rom (
    .cs(cs_o),
    .rd_act(rd_active),
    .idx(addr_o[IDX_W-1:0]),
    .data(ad_o),
    .oe(ad_oe)
  );

  mbr_port_out #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst),
    .wr_evt(wr_rise_evt),
    .is_io(io_s),
    .addr(addr_o),
    .wdata(bus_s[7:0]),
    .q(led_o)
  );
endmodule

// File: rtl/mbr_checker.sv
module mbr_checker (
  input logic        clk,
  input logic        rst,
  input logic        ale_fall_evt,
  input logic        wr_rise_evt,
  input logic        rd_n_i,
  input logic [19:0] addr_o,
  input logic        cs_o,
  input logic [7:0]  ad_o,
  input logic        ad_oe,
  input logic [7:0]  led_o
);
  // R1: address only moves after a strobe fall event
  a_r1_addr_holds: assert property (@(posedge clk) disable iff (rst)
    !ale_fall_evt |=> $stable(addr_o));

  // R2: select agrees with the latched address
  a_r2_cs_window: assert property (@(posedge clk) disable iff (rst)
    cs_o == (addr_o[19:4] == 16'hFFFF));

  // R3: image tail reads back as no-op
  a_r3_fill_nop: assert property (@(posedge clk) disable iff (rst)
    (ad_oe && cs_o && addr_o[3:0] > 4'd5) |-> ad_o == 8'h90);

  // R4: outside the window, a read returns no-op
  a_r4_outside_nop: assert property (@(posedge clk) disable iff (rst)
    (ad_oe && !cs_o) |-> ad_o == 8'h90);

  // R5: enable edges follow the read strobe two edges later
  a_r5_oe_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(ad_oe) |-> !$past(rd_n_i, 2));
  a_r5_oe_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(ad_oe) |-> $past(rd_n_i, 2));

  // R6, R7: output register moves only after a write rise event
  a_r6_led_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_rise_evt |=> $stable(led_o));
endmodule

bind mbus_boot_rom mbr_checker u_chk (
  .clk(clk), .rst(rst),
  .ale_fall_evt(ale_fall_evt), .wr_rise_evt(wr_rise_evt),
  .rd_n_i(rd_n_i), .addr_o(addr_o), .cs_o(cs_o),
  .ad_o(ad_o), .ad_oe(ad_oe), .led_o(led_o)
);

// File: tb/mbus_boot_rom_tb.sv
module mbus_boot_rom_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr_hi_i = '0;
  logic [7:0]  ad_i = '0;
  logic        ale_i = 1'b0, rd_n_i = 1'b1, wr_n_i = 1'b1, io_m_i = 1'b0;
  logic [7:0]  ad_o;
  logic        ad_oe;
  logic [19:0] addr_o;
  logic        cs_o;
  logic [7:0]  led_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mbus_boot_rom u_dut (
    .clk(clk), .rst(rst), .addr_hi_i(addr_hi_i), .ad_i(ad_i),
    .ale_i(ale_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .io_m_i(io_m_i),
    .ad_o(ad_o), .ad_oe(ad_oe), .addr_o(addr_o), .cs_o(cs_o), .led_o(led_o)
  );

  // {wr, io, exp_cs, addr[19:0], wdata, expected}
  localparam int NV = 14;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 20'hFFFF0, 8'h00, 8'hB0},
    {1'b0, 1'b0, 1'b1, 20'hFFFF1, 8'h00, 8'h04},
    {1'b0, 1'b0, 1'b1, 20'hFFFF2, 8'h00, 8'hE6},
    {1'b0, 1'b0, 1'b1, 20'hFFFF3, 8'h00, 8'h00},
    {1'b0, 1'b0, 1'b1, 20'hFFFF4, 8'h00, 8'hEB},
    {1'b0, 1'b0, 1'b1, 20'hFFFF5, 8'h00, 8'hFA},
    {1'b0, 1'b0, 1'b1, 20'hFFFF6, 8'h00, 8'h90},
    {1'b0, 1'b0, 1'b1, 20'hFFFFF, 8'h00, 8'h90},
    {1'b0, 1'b0, 1'b0, 20'hFFFEF, 8'h00, 8'h90},
    {1'b0, 1'b0, 1'b0, 20'h00003, 8'h00, 8'h90},
    {1'b1, 1'b1, 1'b0, 20'h00000, 8'h04, 8'h04},
    {1'b1, 1'b0, 1'b0, 20'h00000, 8'h77, 8'h04},
    {1'b1, 1'b1, 1'b0, 20'h00001, 8'h55, 8'h04},
    {1'b1, 1'b1, 1'b0, 20'h00000, 8'hA5, 8'hA5}
  };

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [19:0] a, input logic io);
    addr_hi_i = a[19:8];
    ad_i      = a[7:0];
    io_m_i    = io;
    ale_i     = 1'b1;
    edges(2);
    ale_i = 1'b0;
    edges(3);
    ad_i = 8'h5A;  // lines now carry something else
    edges(1);
  endtask

  initial begin
    edges(3);
    // R8: reset state
    chk("R8 addr", addr_o, 0);
    chk("R8 cs", cs_o, 0);
    chk("R8 led", led_o, 0);
    chk("R8 oe", ad_oe, 0);
    rst = 1'b0;
    edges(2);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      addr_phase(v[35:16], v[37]);
      chk("R1 addr", addr_o, v[35:16]);
      chk("R2 cs", cs_o, v[36]);
      if (!v[38]) begin
        rd_n_i = 1'b0;
        edges(2);
        chk("R5 oe", ad_oe, 1);
        chk(v[36] ? "R3 rom" : "R4 nop", ad_o, v[7:0]);
        rd_n_i = 1'b1;
        edges(2);
        chk("R5 oe off", ad_oe, 0);
      end else begin
        ad_i   = v[15:8];
        wr_n_i = 1'b0;
        edges(2);
        wr_n_i = 1'b1;
        edges(3);
        chk(v[7:0] == v[15:8] ? "R6 led" : "R7 led", led_o, v[7:0]);
        edges(1);
      end
    end

    // R5: exact enable latency
    addr_phase(20'hFFFF0, 1'b0);
    rd_n_i = 1'b0;
    edges(1);
    chk("R5 oe after 1 edge", ad_oe, 0);
    edges(1);
    chk("R5 oe after 2 edges", ad_oe, 1);
    rd_n_i = 1'b1;
    edges(1);
    chk("R5 oe held 1 edge", ad_oe, 1);
    edges(1);
    chk("R5 oe off 2 edges", ad_oe, 0);

    // R1: address timing and hold while strobe idles
    addr_hi_i = 12'h123; ad_i = 8'h45; ale_i = 1'b1;
    edges(2);
    ale_i = 1'b0;
    edges(2);
    chk("R1 not yet", addr_o, 20'hFFFF0);
    edges(1);
    chk("R1 latched", addr_o, 20'h12345);
    chk("R2 outside", cs_o, 0);
    addr_hi_i = 12'hFFF; ad_i = 8'hF0;
    edges(4);
    chk("R1 held", addr_o, 20'h12345);

    // R6: write timing, and R8 reset mid-run
    addr_phase(20'h00000, 1'b1);
    ad_i = 8'h3C; wr_n_i = 1'b0;
    edges(2);
    wr_n_i = 1'b1;
    edges(2);
    chk("R6 not yet", led_o, 8'hA5);
    edges(1);
    chk("R6 loaded", led_o, 8'h3C);
    rd_n_i = 1'b0;
    rst = 1'b1;
    edges(1);
    chk("R8 led", led_o, 0);
    chk("R8 addr", addr_o, 0);
    chk("R8 oe", ad_oe, 0);
    rst = 1'b0; rd_n_i = 1'b1;
    edges(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule